// File: doc/BRIEF.md
# Write-Progress Status Read Path

This block produces the read data of a byte-wide nonvolatile memory model. When no internal programming cycle is running, a read returns the array byte at the presented address. While the programming sequencer reports that it is busy, a read returns a status byte instead. The top bit of that byte is the inverse of the top bit of the byte most recently written. The next bit changes value on every new read access. All other bits are zero. A host can therefore poll either bit to find out when programming has finished.

All inputs are sampled on the rising clock edge and both outputs are registered, so a read presented in one cycle appears on the outputs one cycle later. The bus is driven only in a read window: chip enable low, output enable low, write enable high. Outside that window the drive flag is low and the data lines read as zero. A read access begins on the first cycle of a read window that follows a cycle outside one. An access therefore starts again when output enable, chip enable or write enable leaves its read level and comes back. The toggle flip-flop advances only when an access begins while the sequencer is busy.

Top module: `rdp_status_read`

## Requirements
- R1: During reset and in the first cycle after it, `rd_drive` is 0 and `rd_data` is 0.
- R2: `rd_drive` is 1 in the cycle after a cycle in which `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 after any other input combination.
- R3: When a read window is sampled with `busy`=0, the next cycle's `rd_data` equals the array byte `arr_rdata` that was present at that edge. `arr_addr` always equals `addr`.
- R4: When a read window is sampled with `busy`=1, bit DW-1 of the next cycle's `rd_data` is the inverse of bit DW-1 of `last_data`. This holds for any address and from the first access after programming starts.
- R5: While busy, bit DW-2 of `rd_data` takes the opposite value in each new read access compared with the previous access.
- R6: While busy, the bits of `rd_data` other than DW-1 and DW-2 are 0.
- R7: A read access starts only when a read window follows a non-read cycle, whether the gap comes from `oe_n` high, `ce_n` high or `we_n` low. Holding the window open for several cycles keeps bit DW-2 unchanged.
- R8: Once `busy` falls, the next read cycle returns true array data on all bits, even within an access that is held open. The toggle bit does not advance while `busy`=0.
- R9: Whenever `rd_drive` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Read address |
| busy | input | 1 | Programming cycle in progress, from the sequencer |
| last_data | input | DW | Byte most recently written, from the sequencer |
| arr_rdata | input | DW | Array byte at `arr_addr` |
| arr_addr | output | AW | Address presented to the array |
| rd_data | output | DW | Registered read data |
| rd_drive | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The bench builds the block with AW=4 and DW=8. With those values every array address can be read back against an arithmetic model, and all 256 values of the last written byte can be polled as separate accesses. Those same accesses provide a long run of toggle alternations. All eight enable combinations are swept both idle and busy. Access restarts through each of the three enables, held-open accesses, and the busy-to-idle change in the middle of an access are each driven directly.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;

  // A cycle is a read window when both enables are low and write is idle.
  function automatic logic read_window(input logic ce_n, input logic oe_n,
                                       input logic we_n);
    return !ce_n && !oe_n && we_n;
  endfunction

  // Selects the source of the read byte for a given programming state.
  function automatic rd_src_e pick_source(input logic busy);
    return busy ? SRC_STATUS : SRC_ARRAY;
  endfunction

endpackage

// File: rtl/rdp_access_detect.sv
module rdp_access_detect
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_en,
  output logic access_start
);

  logic rd_en_q;

  assign rd_en        = read_window(ce_n, oe_n, we_n);
  assign access_start = rd_en && !rd_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_en_q <= 1'b0;
    else        rd_en_q <= rd_en;
  end

endmodule

// File: rtl/rdp_toggle.sv
module rdp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic access_start,
  input  logic busy,
  output logic tog_q,
  output logic tog_next
);

  logic tog_adv;

  assign tog_adv  = access_start && busy;
  assign tog_next = tog_q ^ tog_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_next;
  end

endmodule

// File: rtl/rdp_out_mux.sv
module rdp_out_mux
  import rdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          busy,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_rdata,
  input  logic          tog_next,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);

  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] status_word;
  logic [DW-1:0] data_next;
  rd_src_e       src;

  // Build the status byte bit by bit.
  for (genvar b = 0; b < DW; b++) begin : g_status
    if (b == POLL_BIT) begin : g_poll
      assign status_word[b] = ~last_data[POLL_BIT];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_word[b] = tog_next;
    end else begin : g_zero
      assign status_word[b] = 1'b0;
    end
  end

  assign src = pick_source(busy);

  always_comb begin
    data_next = '0;
    if (rd_en) data_next = (src == SRC_STATUS) ? status_word : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= data_next;
      rd_drive <= rd_en;
    end
  end

endmodule

// File: rtl/rdp_status_read.sv
module rdp_status_read #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);

  logic rd_en;
  logic access_start;
  logic tog_q;
  logic tog_next;

  assign arr_addr = addr;

  rdp_access_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .rd_en        (rd_en),
    .access_start (access_start)
  );

  rdp_toggle u_toggle (
    .clk          (clk),
    .rst_n        (rst_n),
    .access_start (access_start),
    .busy         (busy),
    .tog_q        (tog_q),
    .tog_next     (tog_next)
  );

  rdp_out_mux #(.DW(DW)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .busy      (busy),
    .last_data (last_data),
    .arr_rdata (arr_rdata),
    .tog_next  (tog_next),
    .rd_data   (rd_data),
    .rd_drive  (rd_drive)
  );

endmodule

// File: rtl/rdp_status_read_chk.sv
module rdp_status_read_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          busy,
  input logic [DW-1:0] last_data,
  input logic [DW-1:0] arr_rdata,
  input logic [DW-1:0] rd_data,
  input logic          rd_drive,
  input logic          access_start,
  input logic          tog_q
);

  localparam logic [DW-1:0] LOW_MASK = {2'b00, {(DW-2){1'b1}}};

  logic win;
  assign win = !ce_n && !oe_n && we_n;

  a_r2_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_drive == $past(win));

  a_r9_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0);

  a_r3_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !busy) |=> rd_data == $past(arr_rdata));

  a_r4_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (win && busy) |=> rd_data[DW-1] == !$past(last_data[DW-1]));

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (win && busy) |=> (rd_data & LOW_MASK) == '0);

  a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (access_start && busy) |=> tog_q != $past(tog_q));

  a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(access_start && busy) |=> $stable(tog_q));

endmodule

bind rdp_status_read rdp_status_read_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_n         (ce_n),
  .oe_n         (oe_n),
  .we_n         (we_n),
  .busy         (busy),
  .last_data    (last_data),
  .arr_rdata    (arr_rdata),
  .rd_data      (rd_data),
  .rd_drive     (rd_drive),
  .access_start (access_start),
  .tog_q        (tog_q)
);

// File: tb/tb_rdp_status_read.sv
module tb_rdp_status_read;

  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic          busy;
  logic [DW-1:0] last_data;
  logic [DW-1:0] arr_rdata;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return 8'(a * 29 + 7);
  endfunction

  assign arr_rdata = model(arr_addr);

  rdp_status_read #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .last_data(last_data), .arr_rdata(arr_rdata),
    .arr_addr(arr_addr), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic prev_tog;
    logic cur;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; busy = 1'b0; last_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", 32'(rd_drive), 0);
    chk("R1 data in reset", 32'(rd_data), 0);
    rst_n = 1'b1;
    step(1, 1, 1);
    chk("R1 drive after reset", 32'(rd_drive), 0);
    chk("R1 data after reset", 32'(rd_data), 0);

    // R2 / R9 / R3: all enable combinations, idle, separated by a gap.
    for (int busy_i = 0; busy_i < 2; busy_i++) begin
      busy = busy_i[0];
      last_data = 8'h35;
      for (int k = 0; k < 8; k++) begin
        logic exp_drv;
        addr = 4'(k + 3);
        step(1, 1, 1);
        step(k[0], k[1], k[2]);
        exp_drv = !k[0] && !k[1] && k[2];
        chk("R2 drive", 32'(rd_drive), 32'(exp_drv));
        if (!exp_drv) chk("R9 idle bus zero", 32'(rd_data), 0);
        else if (!busy) chk("R3 array data", 32'(rd_data), 32'(model(addr)));
        else chk("R6 low bits", 32'(rd_data[5:0]), 0);
      end
    end
    busy = 1'b0;
    step(1, 1, 1);

    // R3: sweep every address within one held access.
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      step(0, 0, 1);
      chk("R3 address sweep", 32'(rd_data), 32'(model(4'(a))));
      chk("R3 address passthrough", 32'(arr_addr), 32'(a));
    end
    step(1, 1, 1);

    // R4 / R5 / R6: every last-written value, one fresh access each.
    busy = 1'b1;
    prev_tog = 1'b0;
    for (int d = 0; d < 256; d++) begin
      last_data = 8'(d);
      addr = 4'(d);
      step(0, 1, 1);
      step(0, 0, 1);
      chk("R4 poll bit", 32'(rd_data[7]), 32'(!d[7]));
      chk("R6 zero bits", 32'(rd_data[5:0]), 0);
      if (d > 0) chk("R5 toggle alternates", 32'(rd_data[6]), 32'(!prev_tog));
      prev_tog = rd_data[6];
    end

    // R7: held access keeps the toggle bit.
    step(0, 0, 1);
    chk("R7 held access", 32'(rd_data[6]), 32'(prev_tog));
    step(0, 0, 1);
    chk("R7 held access again", 32'(rd_data[6]), 32'(prev_tog));
    // R7: restart through chip enable.
    step(1, 0, 1);
    step(0, 0, 1);
    cur = rd_data[6];
    chk("R7 restart via chip enable", 32'(cur), 32'(!prev_tog));
    prev_tog = cur;
    // R7: restart through write enable.
    step(0, 0, 0);
    chk("R7 write cycle not driven", 32'(rd_drive), 0);
    step(0, 0, 1);
    cur = rd_data[6];
    chk("R7 restart via write enable", 32'(cur), 32'(!prev_tog));
    prev_tog = cur;
    // R7: restart through both enables.
    step(1, 1, 1);
    step(0, 0, 1);
    cur = rd_data[6];
    chk("R7 restart via both enables", 32'(cur), 32'(!prev_tog));
    prev_tog = cur;

    // R8: busy falls inside a held access.
    addr = 4'd9;
    busy = 1'b0;
    step(0, 0, 1);
    chk("R8 true data after busy", 32'(rd_data), 32'(model(4'd9)));
    // R8: toggle frozen while idle: idle accesses, then busy again.
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1);
      step(0, 0, 1);
      chk("R8 idle access true data", 32'(rd_data), 32'(model(4'd9)));
    end
    step(1, 1, 1);
    busy = 1'b1;
    last_data = 8'h80;
    step(0, 0, 1);
    chk("R8 toggle resumed from frozen value", 32'(rd_data[6]), 32'(!prev_tog));
    chk("R4 poll at restart", 32'(rd_data[7]), 0);
    step(1, 1, 1);
    chk("R9 released bus", 32'(rd_data), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule